// File: doc/BRIEF.md
# Lockable Multi-Bit Control Register

This block holds a 16-bit control word made of four 4-bit redundant boolean fields: block enable, boot-request mode, auto-request mode and command-queue reset. Each field is decoded into a single control bit. A field is true only for the code 4'b0110 and false only for 4'b1001. Any other code is illegal. An illegal field drives its control output false and sets a sticky per-field status bit. Any set status bit raises the recoverable alert output.

Software reaches three word locations through a simple port made of address, write data and write strobe. The read data follows the address without a clock. The first location is a one-way lock. Writing 0 clears it, and once it is clear the control word can no longer be changed. The second location is the control word. The third is the alert status, which also records pulses on an external bus-compare input. Status bits are cleared by writing 0 to them.

Top module: `lmb_ctrl_reg`

## Requirements
- R1: After reset the control word (address 0x1) reads 0x9999, the lock (address 0x0, bit 0) reads 1, the status (address 0x2) reads 0, and all four control outputs and the alert are 0.
- R2: The fields sit at enable [3:0], boot-request [7:4], auto-request [11:8] and queue-reset [15:12]. A field holding 4'b0110 drives its output 1 and a field holding 4'b1001 drives it 0, starting in the cycle after the write edge.
- R3: A field holding any code other than 4'b0110 or 4'b1001 drives its control output 0.
- R4: An illegal field sets its status bit one clock after the code is stored: enable sets bit 0, boot-request bit 1, auto-request bit 2 and queue-reset bit 3.
- R5: Writing status bits as 0 clears them and writing them as 1 leaves them unchanged. While the field behind a bit is still illegal, that bit stays set even across a clearing write.
- R6: A cycle with bus_cmp_i high sets status bit 12 at that clock edge.
- R7: recov_alert_o is 1 exactly when any status bit is set. alert_sts_o mirrors the 13-bit status.
- R8: Writing 0 to lock bit 0 clears the lock. Writing 1 never sets it again.
- R9: While the lock is 0, writes to the control word are ignored, including writes of illegal codes.
- R10: Reads of an unmapped address return 0. Bits 31:16 of the control word and bits 11:4 of the status read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Word address for read and write |
| wdata_i | input | DATA_W | Write data |
| we_i | input | 1 | Write strobe |
| rdata_o | output | DATA_W | Read data for addr_i, combinational |
| bus_cmp_i | input | 1 | Bus-compare alert event |
| enable_o | output | 1 | Decoded enable field |
| boot_req_o | output | 1 | Decoded boot-request mode field |
| auto_req_o | output | 1 | Decoded auto-request mode field |
| fifo_rst_o | output | 1 | Decoded command-queue reset field |
| recov_alert_o | output | 1 | Recoverable alert |
| alert_sts_o | output | 13 | Alert status bits |

## Verification
A control write takes effect at its write edge. The decoded outputs and the read data are therefore due in the half cycle that follows that edge. Status bits caused by an illegal field appear one clock later, because the check looks at the stored code. The alert follows the status in the same cycle. A bus-compare pulse and a status-clearing write act at their own edge. Inputs are driven on the falling edge, and each check samples on the falling edge after the last register on the path has been clocked. Status checks after a control write therefore wait one extra cycle.

// File: rtl/lmb_ctrl_pkg.sv
package lmb_ctrl_pkg;
  localparam int unsigned FIELD_W    = 4;
  localparam int unsigned NUM_FIELDS = 4;
  localparam int unsigned CTRL_W     = FIELD_W * NUM_FIELDS;
  localparam int unsigned STS_W      = 13;
  localparam int unsigned STS_BUS_CMP = 12;

  localparam logic [FIELD_W-1:0] MUBI_TRUE  = 4'b0110;
  localparam logic [FIELD_W-1:0] MUBI_FALSE = 4'b1001;

  localparam int unsigned ADDR_LOCK = 0;
  localparam int unsigned ADDR_CTRL = 1;
  localparam int unsigned ADDR_STS  = 2;

  typedef enum logic [1:0] {
    FLD_ENABLE = 2'd0,
    FLD_BOOT   = 2'd1,
    FLD_AUTO   = 2'd2,
    FLD_FIFO   = 2'd3
  } field_e;
endpackage

// File: rtl/lmb_field_dec.sv
module lmb_field_dec
  import lmb_ctrl_pkg::*;
(
  input  logic [FIELD_W-1:0] code_i,
  output logic               true_o,
  output logic               illegal_o
);
  logic is_true, is_false;
  assign is_true   = (code_i == MUBI_TRUE);
  assign is_false  = (code_i == MUBI_FALSE);
  // illegal codes resolve to false
  assign true_o    = is_true;
  assign illegal_o = !(is_true || is_false);
endmodule

// File: rtl/lmb_lock_reg.sv
module lmb_lock_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic lock_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    lock_o <= 1'b1;
    else if (clr_i) lock_o <= 1'b0;
  end
endmodule

// File: rtl/lmb_alert_sts.sv
module lmb_alert_sts #(
  parameter int unsigned W = 13
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] sts_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 sts_o[b] <= 1'b0;
      else if (set_i[b])           sts_o[b] <= 1'b1;  // set wins over clear
      else if (wr_i && !wdata_i[b]) sts_o[b] <= 1'b0;
    end
  end
endmodule

// File: rtl/lmb_ctrl_reg.sv
module lmb_ctrl_reg
  import lmb_ctrl_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              bus_cmp_i,
  output logic              enable_o,
  output logic              boot_req_o,
  output logic              auto_req_o,
  output logic              fifo_rst_o,
  output logic              recov_alert_o,
  output logic [STS_W-1:0]  alert_sts_o
);
  localparam logic [CTRL_W-1:0] CTRL_RST = {NUM_FIELDS{MUBI_FALSE}};

  logic sel_lock, sel_ctrl, sel_sts;
  assign sel_lock = (addr_i == ADDR_W'(ADDR_LOCK));
  assign sel_ctrl = (addr_i == ADDR_W'(ADDR_CTRL));
  assign sel_sts  = (addr_i == ADDR_W'(ADDR_STS));

  logic lock_q;
  lmb_lock_reg u_lock (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (we_i && sel_lock && !wdata_i[0]),
    .lock_o (lock_q)
  );

  logic [CTRL_W-1:0] ctrl_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         ctrl_q <= CTRL_RST;
    else if (we_i && sel_ctrl && lock_q) ctrl_q <= wdata_i[CTRL_W-1:0];
  end

  logic [NUM_FIELDS-1:0] fld_true, fld_bad;
  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_fld
    lmb_field_dec u_dec (
      .code_i    (ctrl_q[f*FIELD_W +: FIELD_W]),
      .true_o    (fld_true[f]),
      .illegal_o (fld_bad[f])
    );
  end

  assign enable_o   = fld_true[FLD_ENABLE];
  assign boot_req_o = fld_true[FLD_BOOT];
  assign auto_req_o = fld_true[FLD_AUTO];
  assign fifo_rst_o = fld_true[FLD_FIFO];

  logic [STS_W-1:0] sts_set, sts_q;
  always_comb begin
    sts_set = '0;
    sts_set[NUM_FIELDS-1:0] = fld_bad;
    sts_set[STS_BUS_CMP]    = bus_cmp_i;
  end

  lmb_alert_sts #(.W(STS_W)) u_sts (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (sts_set),
    .wr_i    (we_i && sel_sts),
    .wdata_i (wdata_i[STS_W-1:0]),
    .sts_o   (sts_q)
  );

  assign alert_sts_o   = sts_q;
  assign recov_alert_o = |sts_q;

  always_comb begin
    rdata_o = '0;
    if (sel_lock)      rdata_o = DATA_W'(lock_q);
    else if (sel_ctrl) rdata_o = DATA_W'(ctrl_q);
    else if (sel_sts)  rdata_o = DATA_W'(sts_q);
  end
endmodule

// File: rtl/lmb_ctrl_reg_chk.sv
module lmb_ctrl_reg_chk
  import lmb_ctrl_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              we_i,
  input logic              bus_cmp_i,
  input logic              lock_q,
  input logic [CTRL_W-1:0] ctrl_q,
  input logic [STS_W-1:0]  sts_q,
  input logic              enable_o,
  input logic              recov_alert_o
);
  logic [NUM_FIELDS-1:0] bad;
  always_comb begin
    for (int f = 0; f < NUM_FIELDS; f++) begin
      bad[f] = (ctrl_q[f*FIELD_W +: FIELD_W] != MUBI_TRUE) &&
               (ctrl_q[f*FIELD_W +: FIELD_W] != MUBI_FALSE);
    end
  end

  logic ctrl_wr, sts_wr;
  assign ctrl_wr = we_i && (addr_i == ADDR_W'(ADDR_CTRL));
  assign sts_wr  = we_i && (addr_i == ADDR_W'(ADDR_STS));

  // R3
  illegal_is_false_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad[0] |-> !enable_o);

  // R4
  illegal_sets_sts_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad[0] |=> sts_q[0]);

  // R5
  w0c_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_wr && !wdata_i[1] && !bad[1]) |=> !sts_q[1]);

  // R6
  bus_cmp_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_cmp_i |=> sts_q[STS_BUS_CMP]);

  // R7
  alert_has_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(recov_alert_o) |-> $past((|bad) || bus_cmp_i));

  // R8
  lock_one_way_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lock_q |=> !lock_q);

  // R9
  locked_ctrl_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lock_q && ctrl_wr) |=> $stable(ctrl_q));
endmodule

bind lmb_ctrl_reg lmb_ctrl_reg_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .addr_i        (addr_i),
  .wdata_i       (wdata_i),
  .we_i          (we_i),
  .bus_cmp_i     (bus_cmp_i),
  .lock_q        (lock_q),
  .ctrl_q        (ctrl_q),
  .sts_q         (sts_q),
  .enable_o      (enable_o),
  .recov_alert_o (recov_alert_o)
);

// File: tb/tb_lmb_ctrl_reg.sv
`timescale 1ns/1ps
module tb_lmb_ctrl_reg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 4;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [DATA_W-1:0] wdata_i = '0;
  logic              we_i = 1'b0;
  logic [DATA_W-1:0] rdata_o;
  logic              bus_cmp_i = 1'b0;
  logic              enable_o, boot_req_o, auto_req_o, fifo_rst_o, recov_alert_o;
  logic [12:0]       alert_sts_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  lmb_ctrl_reg #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) dut (
    .clk_i, .rst_ni, .addr_i, .wdata_i, .we_i, .rdata_o, .bus_cmp_i,
    .enable_o, .boot_req_o, .auto_req_o, .fifo_rst_o, .recov_alert_o, .alert_sts_o
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk_i);
    addr_i = ADDR_W'(a); wdata_i = d; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0; wdata_i = '0;
  endtask

  task automatic rd_chk(input string tag, input int a, input logic [31:0] exp);
    addr_i = ADDR_W'(a);
    #1;
    chk(tag, rdata_o, exp);
  endtask

  function automatic logic [31:0] outs();
    return {28'd0, fifo_rst_o, auto_req_o, boot_req_o, enable_o};
  endfunction

  task automatic t_reset();
    rd_chk("R1 ctrl", 1, 32'h9999);
    rd_chk("R1 lock", 0, 32'h1);
    rd_chk("R1 sts", 2, 32'h0);
    chk("R1 outs", outs(), 32'h0);
    chk("R1 alert", {31'd0, recov_alert_o}, 32'h0);
  endtask

  task automatic t_decode();
    wr(1, 32'hFFFF_6996);
    chk("R2 outs 6996", outs(), 32'h9);
    rd_chk("R10 ctrl upper", 1, 32'h6996);
    wr(1, 32'h9669);
    chk("R2 outs 9669", outs(), 32'h6);
    @(negedge clk_i);
    chk("R2 no alert", {31'd0, recov_alert_o}, 32'h0);
  endtask

  task automatic t_illegal();
    wr(1, 32'h99F5);
    chk("R3 outs", outs(), 32'h0);
    @(negedge clk_i);
    chk("R4 sts", 32'(alert_sts_o), 32'h3);
    chk("R7 alert", {31'd0, recov_alert_o}, 32'h1);
    wr(1, 32'h0999);
    @(negedge clk_i);
    chk("R4 fifo bit", 32'(alert_sts_o), 32'hB);
    wr(2, 32'h0);
    chk("R5 still set", 32'(alert_sts_o), 32'h8);
    wr(1, 32'h9999);
    @(negedge clk_i);
    wr(2, 32'h0000_FFFF);
    chk("R5 w1 keeps", 32'(alert_sts_o), 32'h8);
    wr(2, 32'h0);
    chk("R5 cleared", 32'(alert_sts_o), 32'h0);
    chk("R7 alert low", {31'd0, recov_alert_o}, 32'h0);
  endtask

  task automatic t_bus_cmp();
    @(negedge clk_i);
    bus_cmp_i = 1'b1;
    @(negedge clk_i);
    bus_cmp_i = 1'b0;
    rd_chk("R6 sts", 2, 32'h1000);
    chk("R7 alert bus", {31'd0, recov_alert_o}, 32'h1);
    wr(2, 32'h0);
    rd_chk("R6 cleared", 2, 32'h0);
    rd_chk("R10 unmapped", 15, 32'h0);
  endtask

  task automatic t_lock();
    wr(0, 32'h1);
    rd_chk("R8 w1 open", 0, 32'h1);
    wr(1, 32'h6666);
    chk("R9 unlocked write", outs(), 32'hF);
    wr(0, 32'h0);
    rd_chk("R8 cleared", 0, 32'h0);
    wr(0, 32'h1);
    rd_chk("R8 stays", 0, 32'h0);
    wr(1, 32'h9999);
    rd_chk("R9 ignored", 1, 32'h6666);
    chk("R9 outs", outs(), 32'hF);
    wr(1, 32'h1234);
    @(negedge clk_i);
    chk("R9 no sts", 32'(alert_sts_o), 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_decode();
    t_illegal();
    t_bus_cmp();
    t_lock();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule